// File: doc/BRIEF.md
# Branch Resolution and Next-Address Unit

This block resolves every branch-group instruction of a 32-bit accumulator machine that uses 18-bit addresses. For each issued instruction it decides whether control moves, and produces the next value of the instruction address counter. Its inputs are the decoded opcode, the 2-bit M field, the 1-bit C field, the effective address (already resolved), the current counter (which already points at the next sequential instruction), the A accumulator, three index registers, the overflow indicator and the 2-bit condition code. It also produces the side effects the branch group needs: an index-register write, an overflow-clear strobe, privileged-mode set and clear strobes, and memory traffic for the return link and the protected state save.

The surrounding pipeline raises `issue_valid` for one cycle while `busy` is low, with every operand valid in that cycle. Branches that need no memory answer with a one-cycle `res_valid` pulse in the following cycle. Two operations touch memory through a simple request/acknowledge port. The return-link branch reads the word at the effective address and writes it back with the counter in its low 18 bits. The protected call writes a state word to a fixed address. Both report their result only after the memory write has been acknowledged.

Top module: `branch_next_addr`

## Requirements
- R1: After reset, `res_valid`, `mem_req` and `busy` are all 0.
- R2: Opcode 0x58 branches when the accumulator meets the test that M selects: 00 means the whole word is zero, 01 means nonzero, 10 means bit 31 is clear, and 11 means bit 31 is set. A taken branch gives `iac_out` = `eff_addr`. A branch that is not taken gives `iac_out` = `iac_in`, and `res_taken` reports which case occurred.
- R3: Opcode 0x59 with M=01 always branches. With M=11 it branches only when the accumulator holds an even number of one bits.
- R4: Opcode 0x59 with M=10 branches only when `ovf_in` is 1. It pulses `ovf_clr` with the result in both cases.
- R5: Opcode 0x78 forms the mask {M,C}. Mask bit 0 accepts condition code 1, bit 1 accepts code 2 and bit 2 accepts code 3. The branch is taken when the code is accepted, and mask 7 branches whatever the code.
- R6: Opcode 0x5B with M=01/10/11 pulses `idx_we` bit 0/1/2 with `idx_wdata` = `iac_in` and branches. With M=00 it writes nothing and does not branch.
- R7: Opcode 0x5A branches only when the index register that M selects (01/10/11 → register 1/2/3) is zero. With M=00 it does not branch.
- R8: Opcode 0x59 with M=00 first reads the word at `eff_addr`. It then writes back, at the same address, bits 31:18 of that read with `iac_in` in bits 17:0. Only after the write has been acknowledged does it report `iac_out` = `eff_addr`+4.
- R9: Opcode 0x18 writes a state word to `SAVE_ADDR`. The word holds `iac_in` in bits 17:0, `ovf_in` in bit 23 and `cc_in` in bits 25:24, with all other bits 0. After the write has been acknowledged it reports `iac_out` = `PRIV_ENTRY` together with a `priv_set` pulse.
- R10: Opcode 0x79 branches to `eff_addr` and pulses `priv_clr`.
- R11: While `busy` is high, `issue_valid` is ignored. An opcode outside the branch group produces a result with `iac_out` = `iac_in` and no side effect.
- R12: An operation that needs no memory access raises `res_valid` in the cycle after it is issued. Every side-effect strobe is asserted only together with `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Instruction issued this cycle |
| opcode | input | 8 | Decoded operation code |
| m_field | input | 2 | M field |
| c_field | input | 1 | C field |
| eff_addr | input | 18 | Resolved effective address |
| iac_in | input | 18 | Current instruction address counter |
| acc_a | input | 32 | A accumulator |
| idx1_in | input | 18 | Index register 1 |
| idx2_in | input | 18 | Index register 2 |
| idx3_in | input | 18 | Index register 3 |
| ovf_in | input | 1 | Overflow indicator |
| cc_in | input | 2 | Condition code |
| busy | output | 1 | Memory sequence in progress |
| res_valid | output | 1 | Result pulse |
| res_taken | output | 1 | Control moved away from sequential flow |
| iac_out | output | 18 | New counter value |
| idx_we | output | 3 | One-hot index-register write strobe |
| idx_wdata | output | 18 | Index-register write data |
| ovf_clr | output | 1 | Clear the overflow indicator |
| priv_set | output | 1 | Enter privileged mode |
| priv_clr | output | 1 | Leave privileged mode, re-enable protection |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 18 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
Each accumulator test is run on both sides of its boundary:
- zero against a small value,
- the largest positive word against the sign bit alone, and
- two one bits against three.

These pairs separate a test of the whole word from a test of only the sign, and an even bit count from an odd one. The condition mask is driven with masks that include the current code and masks that exclude it, plus mask 7 with code 0, which separates the unconditional case from the ordinary match. The index operations are run with M=00, with a zero register and with a nonzero register. The memory sequences are checked through the final memory contents and the result latency, and a second issue is sent in the middle of the return-link sequence to show that it is ignored.

// File: rtl/brn_pkg.sv
// Package: opcode codes and sequencer states shared by the branch unit.
// Assumes opcodes arrive already decoded to the 8-bit codes listed here.
package brn_pkg;
    localparam logic [7:0] OP_ACC_TEST  = 8'h58;
    localparam logic [7:0] OP_MISC      = 8'h59;
    localparam logic [7:0] OP_XZERO     = 8'h5A;
    localparam logic [7:0] OP_XSET      = 8'h5B;
    localparam logic [7:0] OP_CC_MASK   = 8'h78;
    localparam logic [7:0] OP_PRIV_CALL = 8'h18;
    localparam logic [7:0] OP_PRIV_RET  = 8'h79;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_LINK_RD = 2'd1,
        SQ_LINK_WR = 2'd2,
        SQ_SAVE_WR = 2'd3
    } seq_state_t;
endpackage

// File: rtl/brn_decide.sv
// Module: combinational branch decision for one issued instruction.
// Produces taken/target and side-effect requests; memory operations are
// only flagged here (want_link, want_save) and carried out by brn_mem_seq.
module brn_decide
    import brn_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 32,
    parameter int NUM_X  = 3
) (
    input  logic [7:0]        opcode,
    input  logic [1:0]        m_field,
    input  logic              c_field,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [ADDR_W-1:0] iac_in,
    input  logic [DATA_W-1:0] acc_a,
    input  logic [ADDR_W-1:0] idx_val [NUM_X],
    input  logic              ovf_in,
    input  logic [1:0]        cc_in,
    output logic              taken,
    output logic [ADDR_W-1:0] target,
    output logic [NUM_X-1:0]  idx_we,
    output logic              ovf_clr,
    output logic              priv_clr,
    output logic              want_link,
    output logic              want_save
);
    logic [NUM_X-1:0] x_sel;
    logic [NUM_X-1:0] x_zero;
    logic [2:0]       cc_hit;
    logic [2:0]       mask;

    // Per-register select decode and zero detect.
    for (genvar g = 0; g < NUM_X; g++) begin : g_xreg
        assign x_sel[g]  = (int'(m_field) == g + 1);
        assign x_zero[g] = (idx_val[g] == '0);
    end

    assign cc_hit = {cc_in == 2'd3, cc_in == 2'd2, cc_in == 2'd1};
    assign mask   = {m_field, c_field};

    // Opcode-driven condition evaluation and side-effect selection.
    always_comb begin
        taken     = 1'b0;
        idx_we    = '0;
        ovf_clr   = 1'b0;
        priv_clr  = 1'b0;
        want_link = 1'b0;
        want_save = 1'b0;
        case (opcode)
            OP_ACC_TEST: begin
                case (m_field)
                    2'd0:    taken = (acc_a == '0);
                    2'd1:    taken = (acc_a != '0);
                    2'd2:    taken = !acc_a[DATA_W-1];
                    default: taken = acc_a[DATA_W-1];
                endcase
            end
            OP_MISC: begin
                case (m_field)
                    2'd0: want_link = 1'b1;
                    2'd1: taken = 1'b1;
                    2'd2: begin
                        taken   = ovf_in;
                        ovf_clr = 1'b1;
                    end
                    default: taken = ~^acc_a;
                endcase
            end
            OP_CC_MASK:  taken = (mask == 3'b111) || |(mask & cc_hit);
            OP_XSET: begin
                idx_we = x_sel;
                taken  = |x_sel;
            end
            OP_XZERO:    taken = |(x_sel & x_zero);
            OP_PRIV_CALL: want_save = 1'b1;
            OP_PRIV_RET: begin
                taken    = 1'b1;
                priv_clr = 1'b1;
            end
            default: ;
        endcase
    end

    assign target = taken ? eff_addr : iac_in;
endmodule

// File: rtl/brn_mem_seq.sv
// Module: memory sequencer for the return-link read-modify-write and the
// protected state save. Holds each request until acknowledged; read data
// is taken in the acknowledge cycle.
module brn_mem_seq
    import brn_pkg::*;
#(
    parameter int              ADDR_W    = 18,
    parameter int              DATA_W    = 32,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_link,
    input  logic              start_save,
    input  logic [ADDR_W-1:0] ea,
    input  logic [ADDR_W-1:0] iac,
    input  logic [DATA_W-1:0] save_word,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              done_link,
    output logic              done_save
);
    localparam logic [DATA_W-1:0] KEEP_MASK = {{(DATA_W-ADDR_W){1'b1}}, {ADDR_W{1'b0}}};

    seq_state_t        state;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] iac_q;
    logic [DATA_W-1:0] wdata_q;

    // State machine: idle -> (read -> write) for link, idle -> write for save.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            addr_q  <= '0;
            iac_q   <= '0;
            wdata_q <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start_link) begin
                        state  <= SQ_LINK_RD;
                        addr_q <= ea;
                        iac_q  <= iac;
                    end else if (start_save) begin
                        state   <= SQ_SAVE_WR;
                        addr_q  <= SAVE_ADDR;
                        wdata_q <= save_word;
                    end
                end
                SQ_LINK_RD: begin
                    if (mem_ack) begin
                        wdata_q <= (mem_rdata & KEEP_MASK) | DATA_W'(iac_q);
                        state   <= SQ_LINK_WR;
                    end
                end
                default: begin
                    if (mem_ack) state <= SQ_IDLE;
                end
            endcase
        end
    end

    assign busy      = (state != SQ_IDLE);
    assign mem_req   = busy;
    assign mem_we    = (state == SQ_LINK_WR) || (state == SQ_SAVE_WR);
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign done_link = (state == SQ_LINK_WR) && mem_ack;
    assign done_save = (state == SQ_SAVE_WR) && mem_ack;

    // R8: a pending request keeps its address and direction until acknowledged.
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8: an acknowledged link read is followed by a write to the same address.
    a_r8_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && mem_addr == $past(mem_addr)));
endmodule

// File: rtl/branch_next_addr.sv
// Module: top of the branch resolution unit. Accepts one instruction when
// not busy, registers the result of non-memory branches one cycle later,
// and reports memory branches only after their write is acknowledged.
// Assumes the caller holds off issue while busy is high.
module branch_next_addr
    import brn_pkg::*;
#(
    parameter int                ADDR_W     = 18,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] SAVE_ADDR  = 18'h00030,
    parameter logic [ADDR_W-1:0] PRIV_ENTRY = 18'h00100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [7:0]        opcode,
    input  logic [1:0]        m_field,
    input  logic              c_field,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [ADDR_W-1:0] iac_in,
    input  logic [DATA_W-1:0] acc_a,
    input  logic [ADDR_W-1:0] idx1_in,
    input  logic [ADDR_W-1:0] idx2_in,
    input  logic [ADDR_W-1:0] idx3_in,
    input  logic              ovf_in,
    input  logic [1:0]        cc_in,
    output logic              busy,
    output logic              res_valid,
    output logic              res_taken,
    output logic [ADDR_W-1:0] iac_out,
    output logic [2:0]        idx_we,
    output logic [ADDR_W-1:0] idx_wdata,
    output logic              ovf_clr,
    output logic              priv_set,
    output logic              priv_clr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int NUM_X   = 3;
    localparam int OVF_POS = DATA_W - 9;   // bit 8 counted from the MSB
    localparam int CC_HI   = DATA_W - 7;   // bits 6..7 counted from the MSB
    localparam logic [ADDR_W-1:0] LINK_STEP = ADDR_W'(4);

    logic [ADDR_W-1:0] idx_val [NUM_X];
    logic              d_taken, d_ovf_clr, d_priv_clr, want_link, want_save;
    logic [ADDR_W-1:0] d_target;
    logic [NUM_X-1:0]  d_idx_we;
    logic [DATA_W-1:0] save_word;
    logic              accept, start_link, start_save, done_link, done_save;

    assign idx_val[0] = idx1_in;
    assign idx_val[1] = idx2_in;
    assign idx_val[2] = idx3_in;

    brn_decide #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_X(NUM_X)) u_decide (
        .opcode(opcode), .m_field(m_field), .c_field(c_field),
        .eff_addr(eff_addr), .iac_in(iac_in), .acc_a(acc_a),
        .idx_val(idx_val), .ovf_in(ovf_in), .cc_in(cc_in),
        .taken(d_taken), .target(d_target), .idx_we(d_idx_we),
        .ovf_clr(d_ovf_clr), .priv_clr(d_priv_clr),
        .want_link(want_link), .want_save(want_save)
    );

    // State word for the protected call: counter low, overflow and code above.
    always_comb begin
        save_word                   = '0;
        save_word[ADDR_W-1:0]       = iac_in;
        save_word[OVF_POS]          = ovf_in;
        save_word[CC_HI -: 2]       = cc_in;
    end

    assign accept     = issue_valid && !busy;
    assign start_link = accept && want_link;
    assign start_save = accept && want_save;

    brn_mem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SAVE_ADDR(SAVE_ADDR)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_link(start_link), .start_save(start_save),
        .ea(eff_addr), .iac(iac_in), .save_word(save_word),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done_link(done_link), .done_save(done_save)
    );

    // Result register: one-cycle pulse for direct branches or sequence completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_taken <= 1'b0;
            iac_out   <= '0;
            idx_we    <= '0;
            idx_wdata <= '0;
            ovf_clr   <= 1'b0;
            priv_set  <= 1'b0;
            priv_clr  <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            idx_we    <= '0;
            ovf_clr   <= 1'b0;
            priv_set  <= 1'b0;
            priv_clr  <= 1'b0;
            if (done_link) begin
                res_valid <= 1'b1;
                res_taken <= 1'b1;
                iac_out   <= mem_addr + LINK_STEP;
            end else if (done_save) begin
                res_valid <= 1'b1;
                res_taken <= 1'b1;
                iac_out   <= PRIV_ENTRY;
                priv_set  <= 1'b1;
            end else if (accept && !want_link && !want_save) begin
                res_valid <= 1'b1;
                res_taken <= d_taken;
                iac_out   <= d_target;
                idx_we    <= d_idx_we;
                idx_wdata <= iac_in;
                ovf_clr   <= d_ovf_clr;
                priv_clr  <= d_priv_clr;
            end
        end
    end

    // R12: side-effect strobes never appear without a result.
    a_r12_strobe_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (|idx_we || ovf_clr || priv_set || priv_clr) |-> res_valid);

    // R12: a direct branch answers in the next cycle.
    a_r12_direct_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !busy && !want_link && !want_save) |=> res_valid);

    // R6: at most one index register written per result.
    a_r6_one_index: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(idx_we));

    // R11: no memory traffic while idle.
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R9: privileged mode is never entered and left in the same result.
    a_r9_priv_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(priv_set && priv_clr));
endmodule

// File: tb/test_branch_next_addr.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares them on each res_valid pulse.
module test_branch_next_addr;
    localparam logic [17:0] SAVE_A  = 18'h00030;
    localparam logic [17:0] ENTRY_A = 18'h00100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [1:0]  m_field = 2'd0;
    logic        c_field = 1'b0;
    logic [17:0] eff_addr = 18'h00200;
    logic [17:0] iac_in = 18'h01000;
    logic [31:0] acc_a = '0;
    logic [17:0] idx1_in = '0, idx2_in = '0, idx3_in = '0;
    logic        ovf_in = 1'b0;
    logic [1:0]  cc_in = 2'd0;
    logic        busy, res_valid, res_taken, ovf_clr, priv_set, priv_clr;
    logic [17:0] iac_out, idx_wdata, mem_addr;
    logic [2:0]  idx_we;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_wdata, mem_rdata;

    typedef struct {
        logic [17:0] iac;
        logic        tk;
        logic [2:0]  xwe;
        logic [17:0] xd;
        logic        oc, ps, pc;
        int          lat;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0, failures = 0, cyc = 0, issue_cyc = 0;
    logic [31:0] mem [64];
    logic [31:0] word_before;

    always #4 clk = ~clk;

    branch_next_addr #(.SAVE_ADDR(SAVE_A), .PRIV_ENTRY(ENTRY_A)) i_branch_next_addr (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .opcode(opcode),
        .m_field(m_field), .c_field(c_field), .eff_addr(eff_addr), .iac_in(iac_in),
        .acc_a(acc_a), .idx1_in(idx1_in), .idx2_in(idx2_in), .idx3_in(idx3_in),
        .ovf_in(ovf_in), .cc_in(cc_in), .busy(busy), .res_valid(res_valid),
        .res_taken(res_taken), .iac_out(iac_out), .idx_we(idx_we), .idx_wdata(idx_wdata),
        .ovf_clr(ovf_clr), .priv_set(priv_set), .priv_clr(priv_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Cycle counter for latency checks.
    always @(posedge clk) cyc <= cyc + 1;

    // Memory model: acknowledges a request one cycle after it is seen.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[5:0]];
                if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
            end
        end
    end

    // Monitor: compares each result with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL R11 unexpected result: iac_out=%h expected none", iac_out);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (iac_out !== e.iac || res_taken !== e.tk || idx_we !== e.xwe ||
                    (e.xwe != 0 && idx_wdata !== e.xd) || ovf_clr !== e.oc ||
                    priv_set !== e.ps || priv_clr !== e.pc ||
                    (e.lat != 0 && cyc - issue_cyc != e.lat)) begin
                    failures++;
                    $display("FAIL %s: iac=%h tk=%b xwe=%b xd=%h oc=%b ps=%b pc=%b lat=%0d expected iac=%h tk=%b xwe=%b xd=%h oc=%b ps=%b pc=%b lat=%0d",
                             e.tag, iac_out, res_taken, idx_we, idx_wdata, ovf_clr, priv_set,
                             priv_clr, cyc - issue_cyc, e.iac, e.tk, e.xwe, e.xd, e.oc, e.ps,
                             e.pc, e.lat);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Driver: pushes the expected item, pulses issue, waits for the result.
    task automatic fire(input logic tk, input logic [2:0] xwe, input logic oc,
                        input logic ps, input logic pc, input int lat,
                        input logic [17:0] target, input string tag);
        exp_t e;
        e.iac = tk ? target : iac_in;
        e.tk = tk; e.xwe = xwe; e.xd = iac_in;
        e.oc = oc; e.ps = ps; e.pc = pc; e.lat = lat; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        issue_valid = 1'b1;
        issue_cyc = cyc;
        @(negedge clk);
        issue_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_op(input logic [7:0] op, input logic [1:0] m, input logic c);
        opcode = op; m_field = m; c_field = c;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        mem[16] = 32'hFFFC_5A5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        check(!res_valid && !mem_req && !busy, "R1 reset outputs",
              {29'd0, res_valid, mem_req, busy}, 32'd0);

        // R2: accumulator tests, both sides of each boundary
        set_op(8'h58, 2'd0, 1'b0); acc_a = 32'h0;
        fire(1, 0, 0, 0, 0, 1, eff_addr, "R2 zero taken");
        acc_a = 32'h5;
        fire(0, 0, 0, 0, 0, 1, eff_addr, "R2 zero not taken");
        set_op(8'h58, 2'd1, 1'b0);
        fire(1, 0, 0, 0, 0, 1, eff_addr, "R2 nonzero taken");
        set_op(8'h58, 2'd2, 1'b0); acc_a = 32'h7FFF_FFFF;
        fire(1, 0, 0, 0, 0, 1, eff_addr, "R2 plus taken");
        acc_a = 32'h8000_0000;
        fire(0, 0, 0, 0, 0, 1, eff_addr, "R2 plus not taken");
        set_op(8'h58, 2'd3, 1'b0);
        fire(1, 0, 0, 0, 0, 1, eff_addr, "R2 minus taken");

        // R3: unconditional and even-parity branches
        set_op(8'h59, 2'd1, 1'b0);
        fire(1, 0, 0, 0, 0, 1, eff_addr, "R3 unconditional");
        set_op(8'h59, 2'd3, 1'b0); acc_a = 32'h0000_0003;
        fire(1, 0, 0, 0, 0, 1, eff_addr, "R3 even taken");
        acc_a = 32'h0000_0007;
        fire(0, 0, 0, 0, 0, 1, eff_addr, "R3 odd not taken");

        // R4: overflow test clears the indicator either way
        set_op(8'h59, 2'd2, 1'b0); ovf_in = 1'b1;
        fire(1, 0, 1, 0, 0, 1, eff_addr, "R4 overflow set");
        ovf_in = 1'b0;
        fire(0, 0, 1, 0, 0, 1, eff_addr, "R4 overflow clear");

        // R5: condition-code masks
        set_op(8'h78, 2'b10, 1'b1); cc_in = 2'd2;
        fire(0, 0, 0, 0, 0, 1, eff_addr, "R5 mask5 cc2");
        cc_in = 2'd3;
        fire(1, 0, 0, 0, 0, 1, eff_addr, "R5 mask5 cc3");
        set_op(8'h78, 2'b11, 1'b1); cc_in = 2'd0;
        fire(1, 0, 0, 0, 0, 1, eff_addr, "R5 mask7 cc0");
        set_op(8'h78, 2'b00, 1'b0); cc_in = 2'd1;
        fire(0, 0, 0, 0, 0, 1, eff_addr, "R5 mask0 cc1");
        set_op(8'h78, 2'b01, 1'b0); cc_in = 2'd2;
        fire(1, 0, 0, 0, 0, 1, eff_addr, "R5 mask2 cc2");

        // R6: set index register, and M=00 no-op
        set_op(8'h5B, 2'd2, 1'b0);
        fire(1, 3'b010, 0, 0, 0, 1, eff_addr, "R6 set index 2");
        set_op(8'h5B, 2'd3, 1'b0);
        fire(1, 3'b100, 0, 0, 0, 1, eff_addr, "R6 set index 3");
        set_op(8'h5B, 2'd0, 1'b0);
        fire(0, 3'b000, 0, 0, 0, 1, eff_addr, "R6 M00 no-op");

        // R7: branch on index zero
        idx1_in = 18'd7; idx3_in = 18'd0;
        set_op(8'h5A, 2'd3, 1'b0);
        fire(1, 0, 0, 0, 0, 1, eff_addr, "R7 index3 zero");
        set_op(8'h5A, 2'd1, 1'b0);
        fire(0, 0, 0, 0, 0, 1, eff_addr, "R7 index1 nonzero");
        set_op(8'h5A, 2'd0, 1'b0);
        fire(0, 0, 0, 0, 0, 1, eff_addr, "R7 M00 no-op");

        // R8 + R11: return link with an ignored second issue mid-sequence
        word_before = mem[16];
        eff_addr = 18'h00010; iac_in = 18'h2ABCD;
        set_op(8'h59, 2'd0, 1'b0);
        begin
            exp_t e;
            e.iac = 18'h00014; e.tk = 1; e.xwe = 0; e.xd = iac_in;
            e.oc = 0; e.ps = 0; e.pc = 0; e.lat = 5; e.tag = "R8 return link";
            sb.push_back(e);
            @(negedge clk); issue_valid = 1'b1; issue_cyc = cyc;
            @(negedge clk); set_op(8'h59, 2'd1, 1'b0);   // R11: ignored while busy
            @(negedge clk); issue_valid = 1'b0;
            while (sb.size() != 0) @(negedge clk);
            repeat (3) @(negedge clk);
        end
        check(mem[16] == {word_before[31:18], 18'h2ABCD}, "R8 link word", mem[16],
              {word_before[31:18], 18'h2ABCD});

        // R9: protected call saves state and enters privileged mode
        iac_in = 18'h20F0F; ovf_in = 1'b1; cc_in = 2'b10;
        set_op(8'h18, 2'd0, 1'b0);
        fire(1, 0, 0, 1, 0, 3, ENTRY_A, "R9 protected call");
        check(mem[48] == ((32'(2) << 24) | (32'(1) << 23) | 32'h20F0F), "R9 state word",
              mem[48], (32'(2) << 24) | (32'(1) << 23) | 32'h20F0F);
        ovf_in = 1'b0;

        // R10: return to application
        eff_addr = 18'h00300;
        set_op(8'h79, 2'd0, 1'b0);
        fire(1, 0, 0, 0, 1, 1, eff_addr, "R10 protected return");

        // R11: opcode outside the group is a no-op; R12 latency is checked throughout
        set_op(8'h00, 2'd1, 1'b1);
        fire(0, 0, 0, 0, 0, 1, eff_addr, "R11 unknown opcode R12");

        repeat (2) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule